// File: doc/BRIEF.md
# Card Command Issue and Status Unit

This block sits between a host register interface and a storage card model. The host writes a 16-bit command word together with a 32-bit argument. The unit decodes the word, forwards the command index and the argument to a card-response port, and reads the card's reply back in the same cycle. The reply is up to 16 bytes plus a byte count. The unit checks the length against the response type and keeps the reply in eight 16-bit response registers. It also updates a 15-bit status register. The interrupt line is the OR of every status bit that the host mask enables.

The host clears status bits by writing ones to them. Commands of the data-transfer class also send a one-cycle start pulse, with the direction bit, to a separate data-path engine. CRC checking and serial bit timing are outside this block. The card port is abstract: the card model must present its reply combinationally while the request is high.

Top module: `cmd_issue_stat`

## Requirements
- R1: After reset, the status, the mask, all eight response registers, the interrupt and the transfer pulse are zero.
- R2: The card request is high in the same cycle as an accepted command write, except for the init-zero case. During that cycle the card index equals command bits [5:0] and the card argument equals the argument input.
- R3: A command with the init flag (bit 7) set and index 0 sends no card request. It zeroes the response registers, sets status bit 0 and changes no other status bit. It never starts a transfer.
- R4: Response type (bits [10:8]) 1, 3 or 6 with fewer than 4 bytes, or type 2 with fewer than 16 bytes, is a timeout. Status bits 0–11 and 14 are cleared, bit 7 is set, and the response registers read zero.
- R5: Every accepted command first zeroes all response registers. For a non-timed-out reply of type 1, 2, 3 or 6, the bytes at offsets 2i and 2i+1 form a word with the first byte high, and that word goes to register 7-i. Types 0, 4, 5 and 7 store nothing.
- R6: For type 1, the card status is the first four bytes in big-endian order. If it has any bit of 0xFDF90000, status bit 14 is set. The busy flag (bit 11) does not change this handling.
- R7: When no card error is flagged, status bits 0–11 and 14 are cleared before the completion bits are set. Bits 12 and 13 are kept.
- R8: For type 3, if card-status bit 31 is 1, status bits 0–12 are cleared. Otherwise status bit 12 is set. R7 then applies.
- R9: For type 6, bytes 2 and 3 form a 16-bit value in big-endian order. If it has any bit of 0xE000, status bit 14 is set.
- R10: A command that does not time out sets status bits 0 and 2 when its index is 12, and sets only bit 0 for any other index.
- R11: While the enable input is low, command writes send no request and leave the status and response registers unchanged.
- R12: A status write clears each bit written as 1. It takes effect before a command in the same cycle. A mask write loads 15 bits. The interrupt equals the OR of status AND mask, with no delay.
- R13: A command of class 3 (bits [13:12]) gives a one-cycle transfer-start pulse in the cycle after the write. The direction output then equals bit 15. Other classes give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; commands are ignored when low |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command word |
| cmd_arg | input | 32 | Command argument |
| stat_wr | input | 1 | Status write-one-to-clear strobe |
| stat_wdata | input | 15 | Bits to clear |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 15 | New interrupt mask |
| card_req | output | 1 | Request to the card model |
| card_idx | output | 6 | Command index to the card |
| card_arg | output | 32 | Argument to the card |
| card_rsp_len | input | 5 | Number of reply bytes returned |
| card_rsp_data | input | 128 | Reply bytes, byte j at bits [8j+7:8j] |
| rsp_regs | output | 128 | Response registers, register k at bits [16k+15:16k] |
| status | output | 15 | Status register |
| irq | output | 1 | Interrupt |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_dir | output | 1 | Direction of the last started transfer |

## Verification
On every cycle, the assertions check the following:
- A timeout never leaves the end-of-command bit set.
- A stop command leaves bits 0 and 2 set.
- A flagged card error lands in bit 14.
- Cleared bits stay clear after a status write.
- Nothing moves while the unit is disabled.
- A transfer pulse has a matching class-3 command behind it.

Only the bench's scenarios show the bit-exact values:
- the full status word after each combination of type, busy flag, length and payload;
- the reversed big-endian packing of the response words;
- the ordering of a same-cycle clear against a command.

// File: rtl/cis_pkg.sv
package cis_pkg;
   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_SHORT = 3'd1,
      K_LONG  = 3'd2,
      K_OCR   = 3'd3,
      K_ADDR  = 3'd6
   } rsp_kind_e;

   typedef struct packed {
      logic init0;
      logic timeout;
      logic err;
      logic ocr_clr;
      logic ocr_set;
      logic store;
      logic stop;
      logic data_cls;
      logic dir;
   } cmd_info_t;

   localparam int ST_EOC  = 0;
   localparam int ST_STOP = 2;
   localparam int ST_TMO  = 7;
   localparam int ST_NRDY = 12;
   localparam int ST_CERR = 14;
   localparam int STOP_IDX = 12;
endpackage

// File: rtl/cis_decode.sv
module cis_decode
   import cis_pkg::*;
#(
   parameter int LEN_W      = 5,
   parameter int LONG_BYTES = 16,
   parameter logic [31:0] SHORT_ERR_MASK = 32'hFDF9_0000,
   parameter logic [15:0] ADDR_ERR_MASK  = 16'hE000
) (
   input  logic [15:0]      cmd_word,
   input  logic [LEN_W-1:0] rsp_len,
   input  logic [31:0]      head,
   output cmd_info_t        info
);
   localparam int SHORT_BYTES = 4;

   rsp_kind_e   kind;
   logic        short_rsp;
   logic [31:0] card_stat;
   logic [15:0] addr_val;
   logic        unused_bits;

   assign unused_bits = ^{cmd_word[14], cmd_word[11], cmd_word[6]};
   assign card_stat = {head[7:0], head[15:8], head[23:16], head[31:24]};
   assign addr_val  = {head[23:16], head[31:24]};

   always_comb begin
      case (cmd_word[10:8])
         3'd1:    kind = K_SHORT;
         3'd2:    kind = K_LONG;
         3'd3:    kind = K_OCR;
         3'd6:    kind = K_ADDR;
         default: kind = K_NONE;
      endcase
      if (kind == K_NONE)      short_rsp = 1'b0;
      else if (kind == K_LONG) short_rsp = rsp_len < LEN_W'(LONG_BYTES);
      else                     short_rsp = rsp_len < LEN_W'(SHORT_BYTES);
   end

   always_comb begin
      info          = '0;
      info.init0    = cmd_word[7] && (cmd_word[5:0] == 6'd0);
      info.timeout  = short_rsp;
      info.err      = !short_rsp &&
                      (((kind == K_SHORT) && |(card_stat & SHORT_ERR_MASK)) ||
                       ((kind == K_ADDR)  && |(addr_val & ADDR_ERR_MASK)));
      info.ocr_clr  = !short_rsp && (kind == K_OCR) && card_stat[31];
      info.ocr_set  = !short_rsp && (kind == K_OCR) && !card_stat[31];
      info.store    = !short_rsp && (kind != K_NONE);
      info.stop     = cmd_word[5:0] == 6'(STOP_IDX);
      info.data_cls = cmd_word[13:12] == 2'd3;
      info.dir      = cmd_word[15];
   end
endmodule

// File: rtl/cis_rsp_store.sv
module cis_rsp_store #(
   parameter int RSP_WORDS = 8,
   parameter int WORD_W    = 16,
   localparam int RSP_W    = RSP_WORDS * WORD_W,
   localparam int WB       = WORD_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             store,
   input  logic [RSP_W-1:0] rsp_data,
   output logic [RSP_W-1:0] rsp_q
);
   logic [RSP_W-1:0] packed_rsp;

   for (genvar gi = 0; gi < RSP_WORDS; gi++) begin : g_word
      for (genvar gb = 0; gb < WB; gb++) begin : g_byte
         assign packed_rsp[(RSP_WORDS-1-gi)*WORD_W + (WB-1-gb)*8 +: 8] =
            rsp_data[(gi*WB + gb)*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rsp_q <= '0;
      else if (go) rsp_q <= store ? packed_rsp : '0;
   end

   AST_RSP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !store) |=> (rsp_q == '0)); // R5
endmodule

// File: rtl/cis_status.sv
module cis_status
   import cis_pkg::*;
#(
   parameter int STAT_W  = 15,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  cmd_info_t         info,
   input  logic              stat_wr,
   input  logic [STAT_W-1:0] stat_wdata,
   input  logic              mask_wr,
   input  logic [STAT_W-1:0] mask_wdata,
   output logic [STAT_W-1:0] stat_q,
   output logic [STAT_W-1:0] mask_q,
   output logic              irq
);
   localparam logic [STAT_W-1:0] KEEP_OK  = STAT_W'(15'h3000);
   localparam logic [STAT_W-1:0] KEEP_OCR = STAT_W'(15'h6000);

   logic [STAT_W-1:0] stat_d;

   always_comb begin
      stat_d = stat_q;
      if (stat_wr) stat_d = stat_d & ~stat_wdata;
      if (go) begin
         if (info.init0) begin
            stat_d[ST_EOC] = 1'b1;
         end else begin
            if (info.ocr_clr) stat_d = stat_d & KEEP_OCR;
            if (info.ocr_set) stat_d[ST_NRDY] = 1'b1;
            if (info.err) stat_d[ST_CERR] = 1'b1;
            else          stat_d = stat_d & KEEP_OK;
            if (info.timeout) begin
               stat_d[ST_TMO] = 1'b1;
            end else begin
               stat_d[ST_EOC] = 1'b1;
               if (info.stop) stat_d[ST_STOP] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= stat_d;
         if (mask_wr) mask_q <= mask_wdata;
      end
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(stat_q & mask_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(stat_q & mask_q);
   end

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !go) |=> ((stat_q & $past(stat_wdata)) == '0)); // R12
   AST_TMO_NO_EOC: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !info.init0 && info.timeout) |=> (stat_q[ST_TMO] && !stat_q[ST_EOC])); // R4
   AST_STOP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !info.init0 && !info.timeout && info.stop) |=> (stat_q[ST_EOC] && stat_q[ST_STOP])); // R10
   AST_CARD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !info.init0 && info.err) |=> stat_q[ST_CERR]); // R6
endmodule

// File: rtl/cmd_issue_stat.sv
module cmd_issue_stat
   import cis_pkg::*;
#(
   parameter int RSP_WORDS = 8,
   parameter int WORD_W    = 16,
   parameter int ARG_W     = 32,
   parameter int STAT_W    = 15,
   parameter int LEN_W     = $clog2(RSP_WORDS * WORD_W / 8 + 1),
   parameter bit IRQ_REG   = 1'b0,
   parameter logic [31:0] SHORT_ERR_MASK = 32'hFDF9_0000,
   parameter logic [15:0] ADDR_ERR_MASK  = 16'hE000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          enable,
   input  logic                          cmd_wr,
   input  logic [15:0]                   cmd_word,
   input  logic [ARG_W-1:0]              cmd_arg,
   input  logic                          stat_wr,
   input  logic [STAT_W-1:0]             stat_wdata,
   input  logic                          mask_wr,
   input  logic [STAT_W-1:0]             mask_wdata,
   output logic                          card_req,
   output logic [5:0]                    card_idx,
   output logic [ARG_W-1:0]              card_arg,
   input  logic [LEN_W-1:0]              card_rsp_len,
   input  logic [RSP_WORDS*WORD_W-1:0]   card_rsp_data,
   output logic [RSP_WORDS*WORD_W-1:0]   rsp_regs,
   output logic [STAT_W-1:0]             status,
   output logic                          irq,
   output logic                          xfer_start,
   output logic                          xfer_dir
);
   localparam int RSP_W      = RSP_WORDS * WORD_W;
   localparam int RSP_BYTES  = RSP_W / 8;

   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("cmd_issue_stat: WORD_W must be a whole number of bytes");
   end
   if (RSP_W < 32) begin : g_bad_depth
      $error("cmd_issue_stat: response storage must hold at least 4 bytes");
   end
   if (STAT_W < 15) begin : g_bad_stat
      $error("cmd_issue_stat: STAT_W must cover bit 14");
   end
   if ((1 << LEN_W) <= RSP_BYTES) begin : g_bad_len
      $error("cmd_issue_stat: LEN_W too narrow for the reply length");
   end

   cmd_info_t info;
   logic      go;

   assign go       = cmd_wr && enable;
   assign card_req = go && !info.init0;
   assign card_idx = cmd_word[5:0];
   assign card_arg = cmd_arg;

   cis_decode #(
      .LEN_W(LEN_W), .LONG_BYTES(RSP_BYTES),
      .SHORT_ERR_MASK(SHORT_ERR_MASK), .ADDR_ERR_MASK(ADDR_ERR_MASK)
   ) u_decode (
      .cmd_word(cmd_word), .rsp_len(card_rsp_len),
      .head(card_rsp_data[31:0]), .info(info)
   );

   cis_rsp_store #(.RSP_WORDS(RSP_WORDS), .WORD_W(WORD_W)) u_store (
      .clk(clk), .rst_n(rst_n), .go(go), .store(info.store && !info.init0),
      .rsp_data(card_rsp_data), .rsp_q(rsp_regs)
   );

   logic [STAT_W-1:0] mask_q;

   cis_status #(.STAT_W(STAT_W), .IRQ_REG(IRQ_REG)) u_status (
      .clk(clk), .rst_n(rst_n), .go(go), .info(info),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .stat_q(status), .mask_q(mask_q), .irq(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_start <= 1'b0;
         xfer_dir   <= 1'b0;
      end else begin
         xfer_start <= card_req && info.data_cls;
         if (card_req && info.data_cls) xfer_dir <= info.dir;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !stat_wr) |=> ($stable(status) && $stable(rsp_regs))); // R11
   AST_XFER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> $past(cmd_wr && enable && (cmd_word[13:12] == 2'd3))); // R13
   AST_NO_REQ_INIT0: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_word[7] && (cmd_word[5:0] == 6'd0)) |-> !card_req); // R3
endmodule

// File: tb/cmd_issue_stat_bench.sv
module cmd_issue_stat_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b1;
   logic         cmd_wr = 1'b0;
   logic [15:0]  cmd_word = '0;
   logic [31:0]  cmd_arg = '0;
   logic         stat_wr = 1'b0;
   logic [14:0]  stat_wdata = '0;
   logic         mask_wr = 1'b0;
   logic [14:0]  mask_wdata = '0;
   logic         card_req;
   logic [5:0]   card_idx;
   logic [31:0]  card_arg;
   logic [4:0]   card_rsp_len = '0;
   logic [127:0] card_rsp_data = '0;
   logic [127:0] rsp_regs;
   logic [14:0]  status;
   logic         irq, xfer_start, xfer_dir;

   int total = 0;
   int bad = 0;
   logic [14:0]  exp_st = '0;
   logic [127:0] exp_rsp = '0;
   logic [14:0]  cur_mask = '0;

   always #5 clk = ~clk;

   cmd_issue_stat u_cmd_issue_stat (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_wr(cmd_wr),
      .cmd_word(cmd_word), .cmd_arg(cmd_arg), .stat_wr(stat_wr),
      .stat_wdata(stat_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
      .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data),
      .rsp_regs(rsp_regs), .status(status), .irq(irq),
      .xfer_start(xfer_start), .xfer_dir(xfer_dir)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat_byte(input int p, input int j);
      case (p)
         0: return (j < 4) ? 8'h00 : 8'(j);
         1: return (j == 0) ? 8'h80 : 8'(j * 13);
         2: return (j == 0) ? 8'h02 : (j == 1) ? 8'h06 : (j == 2) ? 8'h20 : 8'(j * 7);
         default: return (j == 0) ? 8'h00 : (j == 1) ? 8'h06 : (j == 2) ? 8'h1F : 8'(8'hA0 + j);
      endcase
   endfunction

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic set_mask(input logic [14:0] m);
      @(negedge clk);
      mask_wr = 1'b1; mask_wdata = m;
      @(negedge clk);
      mask_wr = 1'b0;
      cur_mask = m;
   endtask

   task automatic clear_stat(input logic [14:0] c);
      @(negedge clk);
      stat_wr = 1'b1; stat_wdata = c;
      @(negedge clk);
      stat_wr = 1'b0;
      exp_st = exp_st & ~c;
      chk(status == exp_st, "R12 w1c", 128'(status), 128'(exp_st));
   endtask

   task automatic issue(input logic [15:0] w, input logic [31:0] a, input int len,
                        input int p, input logic [14:0] clr, input bit en);
      logic [127:0] d;
      logic [31:0]  cs;
      logic [15:0]  av;
      logic [2:0]   t;
      bit init0, short_r, err, want_req, want_x;
      string tag;
      for (int j = 0; j < 16; j++) d[j*8 +: 8] = pat_byte(p, j);
      cs = {d[7:0], d[15:8], d[23:16], d[31:24]};
      av = {d[23:16], d[31:24]};
      t = w[10:8];
      init0 = w[7] && (w[5:0] == 6'd0);
      short_r = ((t == 3'd1 || t == 3'd3 || t == 3'd6) && len < 4) || (t == 3'd2 && len < 16);
      @(negedge clk);
      enable = en; cmd_word = w; cmd_arg = a; card_rsp_len = 5'(len);
      card_rsp_data = d; cmd_wr = 1'b1; stat_wr = (clr != 0); stat_wdata = clr;
      #1;
      want_req = en && !init0;
      chk(card_req == want_req, "R2 req", 128'(card_req), 128'(want_req));
      if (want_req) begin
         chk(card_idx == w[5:0], "R2 idx", 128'(card_idx), 128'(w[5:0]));
         chk(card_arg == a, "R2 arg", 128'(card_arg), 128'(a));
      end
      exp_st = exp_st & ~clr;
      if (!en) tag = "R11";
      else if (init0) tag = "R3";
      else if (short_r) tag = "R4";
      else if (w[5:0] == 6'd12) tag = "R10";
      else if (t == 3'd1) tag = "R6";
      else if (t == 3'd3) tag = "R8";
      else if (t == 3'd6) tag = "R9";
      else tag = "R7";
      if (en) begin
         exp_rsp = '0;
         if (init0) begin
            exp_st[0] = 1'b1;
         end else begin
            err = 1'b0;
            if (!short_r) begin
               if (t == 3'd1) err = |(cs & 32'hFDF9_0000);
               if (t == 3'd6) err = |(av & 16'hE000);
               if (t == 3'd3) begin
                  if (cs[31]) exp_st = exp_st & 15'h6000;
                  else        exp_st[12] = 1'b1;
               end
               if (t == 3'd1 || t == 3'd2 || t == 3'd3 || t == 3'd6)
                  for (int i = 0; i < 8; i++)
                     exp_rsp[(7-i)*16 +: 16] = {d[(2*i)*8 +: 8], d[(2*i+1)*8 +: 8]};
            end
            if (err) exp_st[14] = 1'b1;
            else     exp_st = exp_st & 15'h3000;
            if (short_r)                exp_st[7] = 1'b1;
            else if (w[5:0] == 6'd12)   exp_st = exp_st | 15'h0005;
            else                        exp_st[0] = 1'b1;
         end
      end
      want_x = en && !init0 && (w[13:12] == 2'd3);
      @(negedge clk);
      cmd_wr = 1'b0; stat_wr = 1'b0; stat_wdata = '0; enable = 1'b1;
      chk(status == exp_st, tag, 128'(status), 128'(exp_st));
      chk(rsp_regs == exp_rsp, en ? "R5 rsp" : "R11 rsp", rsp_regs, exp_rsp);
      chk(irq == |(exp_st & cur_mask), "R12 irq", 128'(irq), 128'(|(exp_st & cur_mask)));
      chk(xfer_start == want_x, "R13 start", 128'(xfer_start), 128'(want_x));
      if (want_x) chk(xfer_dir == w[15], "R13 dir", 128'(xfer_dir), 128'(w[15]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      finish_up();
   end

   initial begin
      int n;
      logic [15:0] w;
      int lens [5] = '{0, 3, 4, 15, 16};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(status == '0, "R1 status", 128'(status), 128'(0));
      chk(rsp_regs == '0, "R1 rsp", rsp_regs, 128'(0));
      chk(irq == 1'b0, "R1 irq", 128'(irq), 128'(0));
      chk(xfer_start == 1'b0, "R1 xfer", 128'(xfer_start), 128'(0));
      set_mask(15'h7FFF);
      chk(irq == 1'b0, "R1 mask empty status", 128'(irq), 128'(0));
      set_mask(15'h4081);

      n = 0;
      for (int t = 0; t < 8; t++)
         for (int b = 0; b < 2; b++)
            for (int li = 0; li < 5; li++)
               for (int p = 0; p < 4; p++) begin
                  w = {1'b0, 1'b0, 2'b00, 1'(b), 3'(t), 1'b0, 1'b0, 6'((n * 5) % 64)};
                  issue(w, 32'hA500_0000 + 32'(n) * 32'h0101_0101, lens[li], p, '0, 1'b1);
                  n++;
               end

      // R10 stop index, clean reply
      clear_stat(15'h7FFF);
      issue({4'h0, 1'b0, 3'd1, 8'd12}, 32'h1, 4, 0, '0, 1'b1);
      chk(status == 15'h0005, "R10 stop", 128'(status), 128'h5);
      // R3 init-zero with long reply and data class
      issue({1'b1, 1'b0, 2'd3, 1'b0, 3'd2, 1'b1, 1'b0, 6'd0}, 32'h2, 16, 3, 15'h7FFF, 1'b1);
      chk(status == 15'h0001, "R3 only eoc", 128'(status), 128'h1);
      // init flag with nonzero index behaves normally
      issue({4'h0, 1'b0, 3'd2, 1'b1, 1'b0, 6'd9}, 32'h3, 16, 3, '0, 1'b1);
      // R11 disabled command leaves everything untouched
      issue({4'h3, 1'b0, 3'd1, 8'd5}, 32'h4, 4, 1, '0, 1'b0);
      chk(xfer_start == 1'b0, "R11 no xfer", 128'(xfer_start), 128'(0));
      // R12 same-cycle clear then command
      issue({4'h0, 1'b0, 3'd1, 8'd12}, 32'h5, 4, 1, 15'h7FFF, 1'b1);
      chk(status == 15'h4005, "R12 order", 128'(status), 128'h4005);
      for (int b = 0; b < 15; b++) begin
         set_mask(15'(1 << b));
         chk(irq == exp_st[b], "R12 mask bit", 128'(irq), 128'(exp_st[b]));
      end
      clear_stat(15'h0004);
      clear_stat(15'h4001);
      // R13 transfer pulses
      issue({1'b1, 1'b0, 2'd3, 1'b0, 3'd1, 8'd17}, 32'h6, 4, 0, '0, 1'b1);
      @(negedge clk);
      chk(xfer_start == 1'b0, "R13 one cycle", 128'(xfer_start), 128'(0));
      issue({1'b0, 1'b0, 2'd3, 1'b0, 3'd0, 8'd24}, 32'h7, 0, 0, '0, 1'b1);
      issue({1'b1, 1'b0, 2'd2, 1'b0, 3'd0, 8'd25}, 32'h8, 0, 0, '0, 1'b1);
      chk(xfer_dir == 1'b0, "R13 dir held", 128'(xfer_dir), 128'(0));
      finish_up();
   end
endmodule